// File: doc/BRIEF.md
# Snooping Hash Input Front End

This block feeds a hash engine by listening in on the data stream of a neighbouring cipher engine. The same 64-bit words that move through the cipher engine's FIFO are captured here. That lets one pass over memory produce both ciphertext and an authentication digest. A source select picks which side is watched: words being written into the cipher FIFO, or words being read out of it. A snoop enable and a debug input gate capture, and captured words queue in a small input FIFO. When the FIFO is full, the block holds back the snoop source instead of losing words.

Each job starts with a byte count taken from a descriptor. Bytes go to the downstream hash core over a valid/ready consumer port, at most eight per beat. The release stops exactly at the programmed count. Any extra words stay in the FIFO, for example cipher context that was unloaded and captured together with the payload. They never reach the hash core, so the digest stays correct.

On completion the block raises a registered done flag. It also raises a separate, maskable error flag if words are still left in the FIFO. A flush between jobs empties the FIFO and clears the job state.

Top module: `snoop_hash_front`

## Requirements
- R1: Asynchronous reset behaviour.
  - While `rst_ni` is low, the FIFO is empty and `hash_valid_o`, `done_o` and `fifo_err_o` are 0.
  - `snoop_ready_o` is 1 while `rst_ni` is low.
- R2: Capture condition.
  - A word is captured on a rising clock edge when all of these hold: `snoop_en_i`=1, `debug_i`=0, `snoop_ready_o`=1, and the valid of the selected side is 1.
  - `snoop_src_i`=0 selects the inbound pair (`in_valid_i`/`in_data_i`); `snoop_src_i`=1 selects the outbound pair.
  - The pair that is not selected is ignored.
  - Captured words reach the consumer in capture order.
- R3: While `debug_i`=1 or `snoop_en_i`=0, no word is captured.
- R4: Backpressure.
  - The FIFO holds 16 words. `snoop_ready_o` is 0 exactly when it holds 16.
  - A word offered while the FIFO is full is not stored, and no stored word is overwritten.
- R5: Consumer port, beat validity.
  - `hash_valid_o` is 1 only while a job is running, bytes remain to be released, and the FIFO is not empty.
  - A beat transfers when `hash_valid_o` and `hash_ready_i` are both 1, and pops one word.
  - While `hash_ready_i` is 0, the beat holds stable.
  - `hash_valid_o` is never 1 together with `done_o`.
- R6: Beat sizing.
  - Every beat carries min(remaining bytes, 8) bytes in `hash_nbytes_o`, in lanes 0 upward (lane k is bits 8k+7:8k).
  - Lanes at or above `hash_nbytes_o` are driven 0.
  - `hash_last_o` marks the beat that ends the count.
  - The bytes released over a job total exactly the programmed count, so the last beat of a count that is not a multiple of 8 carries count mod 8 bytes.
- R7: Done flag.
  - `done_o` becomes 1 in the cycle after the clock edge that transfers the final beat.
  - For a zero-byte job, `done_o` becomes 1 two cycles after the start edge.
  - `done_o` stays 1 until the next `job_start_i` or `flush_i`.
- R8: Leftover-data error.
  - `fifo_err_o` is set at the same edge as `done_o`, but only if the FIFO holds at least one word after that edge and `err_mask_i` was 0 in the completing cycle. Otherwise it stays 0.
  - `fifo_err_o` is never 1 without `done_o`.
- R9: Flush.
  - `flush_i`=1 at a clock edge empties the FIFO, ends any running job, and clears `done_o` and `fifo_err_o`.
  - A flush takes priority over a job start and a capture at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Flush between jobs: empties FIFO and clears job state |
| debug_i | input | 1 | Debug mode; suppresses capture |
| snoop_en_i | input | 1 | Snoop enable |
| snoop_src_i | input | 1 | Watched side: 0 inbound, 1 outbound |
| in_valid_i | input | 1 | Word written to the cipher FIFO is present |
| in_data_i | input | 64 | Word written to the cipher FIFO |
| out_valid_i | input | 1 | Word read from the cipher FIFO is present |
| out_data_i | input | 64 | Word read from the cipher FIFO |
| snoop_ready_o | output | 1 | Space available; 0 holds the snoop source |
| job_start_i | input | 1 | Start a job with the count on job_bytes_i |
| job_bytes_i | input | 16 | Descriptor byte count |
| err_mask_i | input | 1 | Suppresses the leftover-data error |
| hash_valid_o | output | 1 | Beat available to the hash core |
| hash_data_o | output | 64 | Beat data, valid bytes from lane 0 |
| hash_nbytes_o | output | 4 | Valid bytes in the beat (1 to 8) |
| hash_last_o | output | 1 | Final beat of the job |
| hash_ready_i | input | 1 | Hash core accepts the beat |
| done_o | output | 1 | Job completed |
| fifo_err_o | output | 1 | Completed with words left in the FIFO |

## Verification
Words are captured from both sides while the other side carries inverted junk. Consuming them in order tells a correct source select apart from a swapped or merged one.

Byte counts are tried in several forms:
- whole words;
- partial final words;
- zero;
- a full 16-word load;
- random counts below the captured total.

Together they separate exact count tracking, lane zeroing and the error decision from an occupancy check that ignores the final pop.

Debug mode, disabled snoop and a flush that coincides with a start and a capture are each followed by a job that must stall with no beat. This shows at the consumer port that nothing was stored. Random hash-ready duty cycles exercise holding a beat under backpressure.

// File: rtl/snoop_hash_pkg.sv
package snoop_hash_pkg;
  localparam int unsigned WORD_W_DEF = 64;
  localparam int unsigned DEPTH_DEF  = 16;
  localparam int unsigned CNT_W_DEF  = 16;

  typedef enum logic {
    SRC_INBOUND  = 1'b0,
    SRC_OUTBOUND = 1'b1
  } snoop_src_e;
endpackage

// File: rtl/snoop_hash_tap.sv
module snoop_hash_tap
  import snoop_hash_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              en_i,
  input  logic              dbg_i,
  input  snoop_src_e        src_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              out_valid_i,
  input  logic [WORD_W-1:0] out_data_i,
  input  logic              space_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o
);
  logic sel_valid;

  always_comb begin
    if (src_i == SRC_OUTBOUND) begin
      sel_valid   = out_valid_i;
      push_data_o = out_data_i;
    end else begin
      sel_valid   = in_valid_i;
      push_data_o = in_data_i;
    end
  end

  assign push_o = en_i && !dbg_i && sel_valid && space_i;
endmodule

// File: rtl/snoop_hash_fifo.sv
module snoop_hash_fifo #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [OCC_W-1:0]  occ_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0]  occ_q;
  logic              wr_en, rd_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == OCC_W'(DEPTH));
  assign occ_o   = occ_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign wr_en   = push_i && !full_o && !flush_i;
  assign rd_en   = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_en) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/snoop_hash_job.sv
module snoop_hash_job #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned OCC_W  = 5,
  localparam int unsigned BYTES = WORD_W / 8,
  localparam int unsigned NB_W  = $clog2(BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] bytes_i,
  input  logic             mask_i,
  input  logic             empty_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             push_i,
  input  logic             ready_i,
  output logic             pop_o,
  output logic             valid_o,
  output logic [NB_W-1:0]  nbytes_o,
  output logic             last_o,
  output logic             done_o,
  output logic             err_o
);
  logic [CNT_W-1:0] rem_q;
  logic             active_q, done_q, err_q;
  logic             finish;
  logic [OCC_W-1:0] occ_after;

  assign valid_o  = active_q && (rem_q != '0) && !empty_i;
  assign pop_o    = valid_o && ready_i;
  assign last_o   = (rem_q <= CNT_W'(BYTES));
  assign nbytes_o = last_o ? rem_q[NB_W-1:0] : NB_W'(BYTES);
  // job ends on an exhausted count or on the final beat
  assign finish    = active_q && ((rem_q == '0) || (pop_o && last_o));
  assign occ_after = occ_i + OCC_W'(push_i) - OCC_W'(pop_o);
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (flush_i) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i) begin
      rem_q    <= bytes_i;
      active_q <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (finish) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b1;
      err_q    <= (occ_after != '0) && !mask_i;
    end else if (pop_o) begin
      rem_q    <= rem_q - CNT_W'(BYTES);
    end
  end
endmodule

// File: rtl/snoop_hash_front.sv
module snoop_hash_front
  import snoop_hash_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  localparam int unsigned NB_W  = $clog2(WORD_W / 8) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              debug_i,
  input  logic              snoop_en_i,
  input  logic              snoop_src_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              out_valid_i,
  input  logic [WORD_W-1:0] out_data_i,
  output logic              snoop_ready_o,
  input  logic              job_start_i,
  input  logic [CNT_W-1:0]  job_bytes_i,
  input  logic              err_mask_i,
  output logic              hash_valid_o,
  output logic [WORD_W-1:0] hash_data_o,
  output logic [NB_W-1:0]   hash_nbytes_o,
  output logic              hash_last_o,
  input  logic              hash_ready_i,
  output logic              done_o,
  output logic              fifo_err_o
);
  localparam int unsigned BYTES = WORD_W / 8;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic              push, pop, empty, full;
  logic [WORD_W-1:0] push_data, rdata;
  logic [OCC_W-1:0]  occ;

  assign snoop_ready_o = !full;

  snoop_hash_tap #(.WORD_W(WORD_W)) u_tap (
    .en_i        (snoop_en_i),
    .dbg_i       (debug_i),
    .src_i       (snoop_src_e'(snoop_src_i)),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_i (out_valid_i),
    .out_data_i  (out_data_i),
    .space_i     (!full),
    .push_o      (push),
    .push_data_o (push_data)
  );

  snoop_hash_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push),
    .wdata_i (push_data),
    .pop_i   (pop),
    .rdata_o (rdata),
    .empty_o (empty),
    .full_o  (full),
    .occ_o   (occ)
  );

  snoop_hash_job #(.WORD_W(WORD_W), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_job (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .start_i  (job_start_i),
    .bytes_i  (job_bytes_i),
    .mask_i   (err_mask_i),
    .empty_i  (empty),
    .occ_i    (occ),
    .push_i   (push),
    .ready_i  (hash_ready_i),
    .pop_o    (pop),
    .valid_o  (hash_valid_o),
    .nbytes_o (hash_nbytes_o),
    .last_o   (hash_last_o),
    .done_o   (done_o),
    .err_o    (fifo_err_o)
  );

  // lanes past the byte count read as zero
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign hash_data_o[8*b +: 8] = (NB_W'(b) < hash_nbytes_o) ? rdata[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/snoop_hash_front_chk.sv
module snoop_hash_front_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NB_W   = 4,
  parameter int unsigned OCC_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              debug_i,
  input logic              snoop_en_i,
  input logic              snoop_ready_o,
  input logic              job_start_i,
  input logic              hash_valid_o,
  input logic [WORD_W-1:0] hash_data_o,
  input logic [NB_W-1:0]   hash_nbytes_o,
  input logic              hash_last_o,
  input logic              hash_ready_i,
  input logic              done_o,
  input logic              fifo_err_o,
  input logic [OCC_W-1:0]  occ_i
);
  localparam int unsigned BYTES = WORD_W / 8;

  assert_no_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((debug_i || !snoop_en_i) && !flush_i) |=> (occ_i <= $past(occ_i)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= OCC_W'(DEPTH));

  assert_full_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == OCC_W'(DEPTH)) |-> !snoop_ready_o);

  assert_beat_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o |-> (hash_nbytes_o != '0 && hash_nbytes_o <= NB_W'(BYTES)));

  assert_beat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hash_valid_o && !hash_ready_i && !flush_i && !job_start_i)
      |=> (hash_valid_o && $stable(hash_data_o) && $stable(hash_nbytes_o)));

  assert_valid_not_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o |-> !done_o);

  assert_full_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hash_valid_o && !hash_last_o) |-> (hash_nbytes_o == NB_W'(BYTES)));

  assert_done_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !flush_i && !job_start_i) |=> done_o);

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_o |-> done_o);

  assert_flush_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (occ_i == '0 && !done_o && !fifo_err_o && !hash_valid_o));
endmodule

bind snoop_hash_front snoop_hash_front_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .NB_W(NB_W), .OCC_W(OCC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .debug_i       (debug_i),
  .snoop_en_i    (snoop_en_i),
  .snoop_ready_o (snoop_ready_o),
  .job_start_i   (job_start_i),
  .hash_valid_o  (hash_valid_o),
  .hash_data_o   (hash_data_o),
  .hash_nbytes_o (hash_nbytes_o),
  .hash_last_o   (hash_last_o),
  .hash_ready_i  (hash_ready_i),
  .done_o        (done_o),
  .fifo_err_o    (fifo_err_o),
  .occ_i         (occ)
);

// File: tb/sim_snoop_hash_front.sv
module sim_snoop_hash_front;
  localparam int W = 64;
  localparam int D = 16;
  localparam int B = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, flush, debug, snoop_en, snoop_src;
  logic          in_valid, out_valid, job_start, err_mask, hash_ready;
  logic [W-1:0]  in_data, out_data;
  logic [15:0]   job_bytes;
  logic          snoop_ready, hash_valid, hash_last, done, fifo_err;
  logic [W-1:0]  hash_data;
  logic [3:0]    hash_nbytes;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] q[$];

  snoop_hash_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .debug_i(debug),
    .snoop_en_i(snoop_en), .snoop_src_i(snoop_src),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_i(out_valid), .out_data_i(out_data),
    .snoop_ready_o(snoop_ready), .job_start_i(job_start),
    .job_bytes_i(job_bytes), .err_mask_i(err_mask),
    .hash_valid_o(hash_valid), .hash_data_o(hash_data),
    .hash_nbytes_o(hash_nbytes), .hash_last_o(hash_last),
    .hash_ready_i(hash_ready), .done_o(done), .fifo_err_o(fifo_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane_mask(input logic [W-1:0] w, input int n);
    logic [W-1:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = w[8*i +: 8];
    return r;
  endfunction

  task automatic snoop(input int src, input logic [W-1:0] d, input bit en, input bit dbg);
    @(negedge clk);
    snoop_en  = en;
    debug     = dbg;
    snoop_src = src[0];
    in_valid  = 1'b1;
    out_valid = 1'b1;
    in_data   = (src == 0) ? d : ~d;
    out_data  = (src == 0) ? ~d : d;
    chk(snoop_ready == (q.size() < D), "R4 snoop_ready", 64'(snoop_ready), 64'(q.size() < D));
    @(posedge clk);
    if (en && !dbg && q.size() < D) q.push_back(d);
    #1;
    in_valid  = 1'b0;
    out_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
    q.delete();
    @(negedge clk);
    chk(!done && !fifo_err, "R9 flush clears flags", {done, fifo_err}, 64'd0);
    chk(snoop_ready, "R9 flush empties", 64'(snoop_ready), 64'd1);
  endtask

  // stall_cycles > 0: job must not deliver beats for that many cycles
  task automatic run_job(input int nbytes, input bit mask, input int ready_pct, input int stall_cycles);
    int rem = nbytes;
    bit finished = 0;
    int cyc = 0;
    int lim = (stall_cycles > 0) ? stall_cycles : 600;
    @(negedge clk);
    job_start  = 1'b1;
    job_bytes  = 16'(nbytes);
    err_mask   = mask;
    hash_ready = 1'b0;
    @(posedge clk);
    #1 job_start = 1'b0;
    while (!finished && cyc < lim) begin
      bit rdy;
      bit ev;
      int n;
      @(negedge clk);
      cyc++;
      rdy = ($urandom % 100) < ready_pct;
      hash_ready = rdy;
      chk(!done, "R7 done low while running", 64'(done), 64'd0);
      if (rem == 0) begin
        chk(!hash_valid, "R5 no beat at zero count", 64'(hash_valid), 64'd0);
        @(posedge clk);
        finished = 1;
      end else begin
        ev = q.size() > 0;
        chk(hash_valid == ev, "R5 hash_valid", 64'(hash_valid), 64'(ev));
        n = (rem < B) ? rem : B;
        if (ev) begin
          chk(hash_nbytes == 4'(n), "R6 nbytes", 64'(hash_nbytes), 64'(n));
          chk(hash_last == (rem <= B), "R6 last", 64'(hash_last), 64'(rem <= B));
          chk(hash_data == lane_mask(q[0], n), "R2 R6 beat data", hash_data, lane_mask(q[0], n));
        end
        @(posedge clk);
        if (ev && rdy) begin
          void'(q.pop_front());
          rem -= n;
          if (rem == 0) finished = 1;
        end
      end
    end
    if (stall_cycles > 0) begin
      chk(!finished, "R3 R9 stalled job", 64'(finished), 64'd0);
    end else if (!finished) begin
      chk(1'b0, "R7 job completion", 64'(rem), 64'd0);
    end else begin
      @(negedge clk);
      hash_ready = 1'b0;
      chk(done, "R7 done after last beat", 64'(done), 64'd1);
      chk(fifo_err == (q.size() != 0 && !mask), "R8 leftover error", 64'(fifo_err),
          64'(q.size() != 0 && !mask));
      chk(!hash_valid, "R5 no beat after done", 64'(hash_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; flush = 1'b0; debug = 1'b0; snoop_en = 1'b0; snoop_src = 1'b0;
    in_valid = 1'b0; out_valid = 1'b0; in_data = '0; out_data = '0;
    job_start = 1'b0; job_bytes = '0; err_mask = 1'b0; hash_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(snoop_ready && !hash_valid && !done && !fifo_err, "R1 reset state",
        {snoop_ready, hash_valid, done, fifo_err}, 64'b1000);
    rst_n = 1'b1;

    // R2 both sides, junk on the other
    for (int i = 0; i < 3; i++) snoop(0, 64'h1111_0000_0000_0000 + 64'(i), 1, 0);
    for (int i = 0; i < 3; i++) snoop(1, 64'h2222_0000_0000_0000 + 64'(i), 1, 0);
    run_job(48, 0, 70, 0);
    do_flush();

    // R6 R8 partial word with leftover, unmasked then masked
    for (int i = 0; i < 3; i++) snoop(0, {$urandom, $urandom}, 1, 0);
    run_job(13, 0, 100, 0);
    do_flush();
    for (int i = 0; i < 3; i++) snoop(1, {$urandom, $urandom}, 1, 0);
    run_job(13, 1, 50, 0);
    do_flush();

    // R7 zero count, leftover word
    snoop(0, 64'hDEAD_BEEF_0000_0001, 1, 0);
    run_job(0, 0, 100, 0);
    repeat (3) @(negedge clk);
    chk(done, "R7 done held", 64'(done), 64'd1);
    do_flush();

    // R4 fill, then offer one more
    for (int i = 0; i < D + 1; i++) snoop(i % 2, {$urandom, 32'(i)}, 1, 0);
    chk(q.size() == D, "R4 model depth", 64'(q.size()), 64'(D));
    run_job(D * B, 0, 60, 0);
    do_flush();

    // R3 debug and disabled snoop capture nothing
    snoop(0, 64'hAAAA, 1, 1);
    snoop(1, 64'hBBBB, 0, 0);
    run_job(8, 0, 100, 5);
    do_flush();

    // R9 flush beats start and capture in same cycle
    snoop(0, 64'h1, 1, 0);
    snoop(0, 64'h2, 1, 0);
    @(negedge clk);
    flush = 1'b1; job_start = 1'b1; job_bytes = 16'd8;
    snoop_en = 1'b1; debug = 1'b0; snoop_src = 1'b0; in_valid = 1'b1; in_data = 64'h3;
    @(posedge clk);
    #1 flush = 1'b0; job_start = 1'b0; in_valid = 1'b0;
    q.delete();
    @(negedge clk);
    chk(!hash_valid && !done, "R9 flush priority", {hash_valid, done}, 64'd0);
    run_job(8, 0, 100, 5);
    do_flush();

    // random jobs
    for (int it = 0; it < 40; it++) begin
      int k = 1 + int'($urandom % 12);
      for (int j = 0; j < k; j++) begin
        int sel = int'($urandom % 6);
        snoop(int'($urandom % 2), {$urandom, $urandom}, sel != 0, sel == 1);
      end
      run_job(int'($urandom % (q.size() * B + 1)), bit'($urandom % 2),
              30 + int'($urandom % 71), 0);
      do_flush();
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule